// File: doc/BRIEF.md
# Auto-Scaling Accumulator Window Cut

This block narrows a wide signed accumulator result to a short output word by taking a contiguous window of bits out of it. The caller supplies the wide value with a valid strobe and a preferred window offset, normally picked to match the scale of the weights that produced the sum. The block checks whether the value fits in that window, meaning nothing is lost above the window's top bit.

When the value does not fit, one of two things happens. With adaptation off, the block keeps the requested window and clamps the output to the largest positive or largest negative word. With adaptation on, it moves the window up to the lowest offset that does hold the value. This gives up low-order precision but keeps the magnitude, and the offset actually used is reported so that later stages can rescale.

The cut is a single registered stage. A result and its valid flag appear on the clock edge after the input is strobed.

Top module: `winc_autocut`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low after an edge at which `in_valid` was low. Result outputs change only on an edge at which `in_valid` is high.
- R2: A window at offset k covers bits [k+15:k] of `acc_in`. It fits when bits [39:k+15] are all equal. If the window at the requested offset fits, then `out_word` = `acc_in[k+15:k]`, `out_ovf` = 0 and `out_win` = k, whatever `adapt_en` is. Bits below the window are dropped, so a negative value rounds toward minus infinity.
- R3: With `adapt_en` = 0 and a requested window that does not fit, `out_ovf` = 1 and `out_win` = the requested offset. `out_word` = 16'h7FFF when `acc_in[39]` = 0 and 16'h8000 when `acc_in[39]` = 1.
- R4: With `adapt_en` = 1, `out_win` is the smallest offset k at or above the requested one whose window fits, and `out_word` = `acc_in[k+15:k]`. `out_ovf` = 1 exactly when k differs from the requested offset.
- R5: A requested offset above 24 is handled as 24. The window [39:24] always fits, so the output is the top 16 bits, with `out_ovf` = 0 and `out_win` = 24.
- R6: While `in_valid` is low, `out_word`, `out_ovf` and `out_win` keep their last values.
- R7: After reset, `out_valid`, `out_word`, `out_ovf` and `out_win` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| acc_in | input | 40 | Signed accumulator value |
| win_base | input | 5 | Requested window offset |
| adapt_en | input | 1 | 1: move the window up on overflow; 0: saturate |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_word | output | 16 | Cut result |
| out_ovf | output | 1 | Requested window could not hold the value |
| out_win | output | 5 | Window offset used for `out_word` |

## Verification
The properties that relate a result to the offset requested one cycle earlier assume that `in_valid`, `adapt_en` and `win_base` are known at every rising edge after reset. Those that compare the used offset with the requested one are enabled only when the request is 24 or below, where no clamping applies. The bench drives every input to a known value on the falling edge, holding it from reset onward. The over-range case of R5 is exercised only by directed vectors, and no property checks it.

// File: rtl/winc_pkg.sv
package winc_pkg;

   // Number of window positions that lie fully inside the accumulator.
   function automatic int win_positions(input int acc_w, input int out_w);
      return acc_w - out_w + 1;
   endfunction

   // Width needed to encode the largest window offset.
   function automatic int win_ofs_width(input int acc_w, input int out_w);
      int n;
      n = acc_w - out_w;
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/winc_fitscan.sv
// For each legal offset k, reports whether the value survives a cut at k:
// every bit from the window's top bit upward must equal the sign bit.
module winc_fitscan #(
   parameter int ACC_W = 40,
   parameter int OUT_W = 16,
   localparam int NPOS = ACC_W - OUT_W + 1
) (
   input  logic [ACC_W-1:0] acc,
   output logic [NPOS-1:0]  fits
);

   for (genvar k = 0; k < NPOS; k++) begin : g_pos
      if (k == NPOS - 1) begin : g_top
         // The top window holds the sign bit itself: it always fits.
         assign fits[k] = 1'b1;
      end else begin : g_mid
         logic [ACC_W-k-OUT_W:0] upper;
         assign upper   = acc[ACC_W-1:k+OUT_W-1];
         assign fits[k] = (&upper) | ~(|upper);
      end
   end

endmodule

// File: rtl/winc_pick.sv
// Picks the lowest fitting offset at or above the requested one.
module winc_pick #(
   parameter int NPOS  = 25,
   parameter int OFS_W = 5
) (
   input  logic [NPOS-1:0]  fits,
   input  logic [OFS_W-1:0] base,
   output logic [OFS_W-1:0] used
);

   always_comb begin
      used = OFS_W'(NPOS - 1);
      for (int k = NPOS - 1; k >= 0; k--) begin
         if (fits[k] && (k >= int'(base))) used = OFS_W'(k);
      end
   end

endmodule

// File: rtl/winc_shape.sv
// Extracts the window at the given offset or forces the saturated code.
module winc_shape #(
   parameter int ACC_W = 40,
   parameter int OUT_W = 16,
   parameter int OFS_W = 5
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [OFS_W-1:0] ofs,
   input  logic             sat,
   output logic [OUT_W-1:0] word
);

   localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

   logic [ACC_W-1:0] shifted;

   always_comb begin
      shifted = acc >> ofs;
      if (sat) word = acc[ACC_W-1] ? NEG_MAX : POS_MAX;
      else     word = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/winc_autocut.sv
module winc_autocut #(
   parameter int ACC_W = 40,
   parameter int OUT_W = 16,
   localparam int NPOS  = winc_pkg::win_positions(ACC_W, OUT_W),
   localparam int OFS_W = winc_pkg::win_ofs_width(ACC_W, OUT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [ACC_W-1:0] acc_in,
   input  logic [OFS_W-1:0] win_base,
   input  logic             adapt_en,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_word,
   output logic             out_ovf,
   output logic [OFS_W-1:0] out_win
);

   localparam int MAX_OFS = NPOS - 1;

   if (OUT_W < 2 || OUT_W >= ACC_W) begin : g_bad_width
      initial $fatal(1, "winc_autocut: OUT_W must be at least 2 and below ACC_W");
   end

   logic [NPOS-1:0]  fits;
   logic [OFS_W-1:0] base_c;
   logic [OFS_W-1:0] pick_ofs;
   logic [OFS_W-1:0] use_ofs;
   logic             ovf_c;
   logic             sat_c;
   logic [OUT_W-1:0] word_c;

   // An out-of-range request is pulled down to the topmost window.
   assign base_c = (int'(win_base) > MAX_OFS) ? OFS_W'(MAX_OFS) : win_base;

   winc_fitscan #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_scan (
      .acc  (acc_in),
      .fits (fits)
   );

   winc_pick #(.NPOS(NPOS), .OFS_W(OFS_W)) u_pick (
      .fits (fits),
      .base (base_c),
      .used (pick_ofs)
   );

   assign ovf_c   = ~fits[base_c];
   assign use_ofs = adapt_en ? pick_ofs : base_c;
   assign sat_c   = ovf_c & ~adapt_en;

   winc_shape #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OFS_W(OFS_W)) u_shape (
      .acc  (acc_in),
      .ofs  (use_ofs),
      .sat  (sat_c),
      .word (word_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_ovf   <= 1'b0;
         out_win   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= word_c;
            out_ovf  <= ovf_c;
            out_win  <= use_ofs;
         end
      end
   end

endmodule

// File: rtl/winc_autocut_chk.sv
module winc_autocut_chk #(
   parameter int ACC_W = 40,
   parameter int OUT_W = 16,
   localparam int NPOS  = winc_pkg::win_positions(ACC_W, OUT_W),
   localparam int OFS_W = winc_pkg::win_ofs_width(ACC_W, OUT_W)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [ACC_W-1:0] acc_in,
   input logic [OFS_W-1:0] win_base,
   input logic             adapt_en,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_word,
   input logic             out_ovf,
   input logic [OFS_W-1:0] out_win
);

   localparam int MAX_OFS = NPOS - 1;
   localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

   logic base_ok;
   assign base_ok = int'(win_base) <= MAX_OFS;

   a_r1_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_word) && $stable(out_ovf) && $stable(out_win)));

   a_r3_fixed_win: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !adapt_en && base_ok) |=> (out_win == $past(win_base)));

   a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !adapt_en) |=> (!out_ovf || out_word == POS_MAX || out_word == NEG_MAX));

   a_r4_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && adapt_en && base_ok) |=> (out_win >= $past(win_base)));

   a_r4_flag_iff_moved: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && adapt_en && base_ok) |=> (out_ovf == (out_win != $past(win_base))));

   a_r5_win_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_win) <= MAX_OFS));

endmodule

bind winc_autocut winc_autocut_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/winc_autocut_tb.sv
module winc_autocut_tb;

   localparam int NV = 15;
   // Vector: {acc, base, adapt, exp_word, exp_ovf, exp_win, req}
   localparam logic [71:0] VEC [NV] = '{
      {40'h00_0000_1234, 5'd0,  1'b0, 16'h1234, 1'b0, 5'd0,  4'd2}, // R2 fits
      {40'hFF_FFFF_FFFB, 5'd0,  1'b0, 16'hFFFB, 1'b0, 5'd0,  4'd2}, // R2 negative
      {40'h00_0001_2340, 5'd4,  1'b0, 16'h1234, 1'b0, 5'd4,  4'd2}, // R2 offset 4
      {40'hFF_FFFF_FFFF, 5'd8,  1'b0, 16'hFFFF, 1'b0, 5'd8,  4'd2}, // R2 floor
      {40'h00_0000_7FFF, 5'd0,  1'b0, 16'h7FFF, 1'b0, 5'd0,  4'd2}, // R2 edge
      {40'hFF_FFFF_8000, 5'd0,  1'b0, 16'h8000, 1'b0, 5'd0,  4'd2}, // R2 edge
      {40'h00_0000_8000, 5'd0,  1'b0, 16'h7FFF, 1'b1, 5'd0,  4'd3}, // R3 just over
      {40'h00_0012_3400, 5'd0,  1'b0, 16'h7FFF, 1'b1, 5'd0,  4'd3}, // R3 positive
      {40'hFF_FFED_CC00, 5'd0,  1'b0, 16'h8000, 1'b1, 5'd0,  4'd3}, // R3 negative
      {40'h00_0012_3400, 5'd0,  1'b1, 16'h48D0, 1'b1, 5'd6,  4'd4}, // R4 positive
      {40'hFF_FFED_CC00, 5'd0,  1'b1, 16'hB730, 1'b1, 5'd6,  4'd4}, // R4 negative
      {40'h00_0000_1234, 5'd0,  1'b1, 16'h1234, 1'b0, 5'd0,  4'd4}, // R4 no move
      {40'h7F_FFFF_FFFF, 5'd20, 1'b1, 16'h7FFF, 1'b1, 5'd24, 4'd4}, // R4 to top
      {40'h80_0000_0000, 5'd30, 1'b0, 16'h8000, 1'b0, 5'd24, 4'd5}, // R5 clamp
      {40'h7F_FFFF_FFFF, 5'd31, 1'b1, 16'h7FFF, 1'b0, 5'd24, 4'd5}  // R5 clamp
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [39:0] acc_in = '0;
   logic [4:0]  win_base = '0;
   logic        adapt_en = 1'b0;
   logic        out_valid;
   logic [15:0] out_word;
   logic        out_ovf;
   logic [4:0]  out_win;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   winc_autocut u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
      .win_base(win_base), .adapt_en(adapt_en), .out_valid(out_valid),
      .out_word(out_word), .out_ovf(out_ovf), .out_win(out_win)
   );

   task automatic check_out(input string req, input logic v, input logic [15:0] w,
                            input logic f, input logic [4:0] o);
      checks++;
      if (out_valid !== v || out_word !== w || out_ovf !== f || out_win !== o) begin
         fails++;
         $display("FAIL %s: got valid=%0b word=%h ovf=%0b win=%0d, want valid=%0b word=%h ovf=%0b win=%0d",
                  req, out_valid, out_word, out_ovf, out_win, v, w, f, o);
      end
   endtask

   task automatic drive(input logic [39:0] a, input logic [4:0] b, input logic ad, input logic v);
      acc_in = a; win_base = b; adapt_en = ad; in_valid = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_out("R7 reset", 1'b0, 16'h0000, 1'b0, 5'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R7 after release", 1'b0, 16'h0000, 1'b0, 5'd0);

      // Table walk: each vector is strobed and checked one edge later (R1).
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][71:32], VEC[i][31:27], VEC[i][26], 1'b1);
         check_out($sformatf("R%0d vec%0d", VEC[i][3:0], i), 1'b1,
                   VEC[i][25:10], VEC[i][9], VEC[i][8:4]);
      end

      // R6: idle cycles with changed inputs leave the result alone; R1 drops valid.
      drive(40'h00_0012_3400, 5'd0, 1'b1, 1'b0);
      check_out("R6 idle holds, R1 valid low", 1'b0, 16'h7FFF, 1'b0, 5'd24);
      drive(40'hFF_FFED_CC00, 5'd3, 1'b0, 1'b0);
      check_out("R6 idle holds", 1'b0, 16'h7FFF, 1'b0, 5'd24);

      // R1: back-to-back strobes update on consecutive edges.
      drive(40'h00_0000_0042, 5'd0, 1'b0, 1'b1);
      check_out("R1 first", 1'b1, 16'h0042, 1'b0, 5'd0);
      drive(40'h00_0000_0084, 5'd1, 1'b0, 1'b1);
      check_out("R1 second", 1'b1, 16'h0042, 1'b0, 5'd1);

      // R4: requested offset above the minimum fitting one stays put.
      drive(40'h00_0000_1234, 5'd2, 1'b1, 1'b1);
      check_out("R4 base above fit", 1'b1, 16'h048D, 1'b0, 5'd2);

      // R7: reset mid-run clears everything.
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R7 mid-run reset", 1'b0, 16'h0000, 1'b0, 5'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule